// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel clock pins for a parallel RGB panel. It also produces a per-pixel request strobe with the current column and row counts, which a pixel fetch engine uses to supply data. It runs on the system clock and steps one pixel position on each cycle in which the pixel-clock enable input is high. Software sets all timing through a small write/read register port. Timing is given as absolute positions: sync widths, line and frame totals, and start/end positions of the active window on each axis, two positions packed per 32-bit word.

The generator starts when the control word has its enable bit set and its disable bit clear. A stop request, made by setting disable or clearing enable, is held off until the last position of the current frame has been emitted. After that the pins return to their idle levels and a status bit reports that the controller is stopped. Timing words written while a frame is in progress are copied into working copies only at the frame boundary, so a frame never mixes two timings. Optional one-clock interrupt pulses mark the first and the last position of each frame.

Top module: `lcd_timing_gen`

## Requirements
- R1: Registers sit at byte offsets: config 0x00, vertical sync width 0x04, horizontal sync width 0x08, totals 0x0C (horizontal total in bits 31:16, vertical total in bits 15:0), horizontal window 0x10 and vertical window 0x14 (start in bits 31:16, end in bits 15:0), control 0x30, status 0x34. Each position field is CNT_W (10) bits wide and reads back zero-extended.
- R2: While running, each cycle with pixEn high latches the current position onto xPos/yPos. The column then advances from 0 to horizontal total minus 1 and wraps, and the row advances on each wrap from 0 to vertical total minus 1. Cycles without pixEn leave the position unchanged.
- R3: Horizontal sync is active while the column is below the horizontal sync width. Vertical sync is active while the row is below the vertical sync width.
- R4: Data enable is active, and pixReq pulses for one clock, only when the column lies in [horizontal start, horizontal end) and the row lies in [vertical start, vertical end).
- R5: Config bit 11 makes hsyncPin active low, bit 8 makes vsyncPin active low and bit 9 makes dePin active low. With a bit clear the pin is active high.
- R6: pclkPin follows pixEn delayed by one clock and is inverted when config bit 10 is set.
- R7: Writing control with bit 3 set and bit 4 clear while stopped restarts at position (0,0) with freshly loaded timing, and clears status bit 0.
- R8: Setting control bit 4, or clearing bit 3, stops the generator only after the final position of the current frame. After that status bit 0 reads 1, the sync and DE pins sit at their idle levels, xPos/yPos read 0, and pixEn has no effect.
- R9: With control bit 12 set, sofIrq pulses on the clock that presents position (0,0). With control bit 13 set, eofIrq pulses on the clock that presents the last position of the frame. With either bit clear, its pulse never occurs.
- R10: Timing registers written mid-frame take effect at the next frame start.
- R11: After reset all pins, pulses and position outputs are 0 and status bit 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixEn | input | 1 | Pixel-clock enable, one pixel step per high cycle |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset for write and read |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data for addr |
| hsyncPin | output | 1 | Horizontal sync pin |
| vsyncPin | output | 1 | Vertical sync pin |
| dePin | output | 1 | Data-enable pin |
| pclkPin | output | 1 | Pixel clock pin |
| pixReq | output | 1 | One-clock request for the pixel at xPos/yPos |
| xPos | output | CNT_W | Column of the presented position |
| yPos | output | CNT_W | Row of the presented position |
| sofIrq | output | 1 | Start-of-frame pulse |
| eofIrq | output | 1 | End-of-frame pulse |

## Verification
The bench goes after the edges of the active window. Here a comparison written with the wrong inclusive/exclusive sense adds or drops a column or row of pixel requests. It also checks the line and frame wrap, where an off-by-one total lengthens every line. It rewrites window and sync words in the middle of a frame, so a design that applies them at once produces a torn frame that differs from the expected one at the very next pixel. It issues stop requests partway through a frame, so a design that halts at once cuts the frame short and raises the stopped status too early. It runs frames with interrupts masked and with all polarities inverted, where an idle level taken from the wrong sense shows as an inverted pin during blanking and after stop.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  // register byte offsets (software decodes these)
  localparam int OFF_CFG   = 'h00;
  localparam int OFF_VSW   = 'h04;
  localparam int OFF_HSW   = 'h08;
  localparam int OFF_TOT   = 'h0C;
  localparam int OFF_HWIN  = 'h10;
  localparam int OFF_VWIN  = 'h14;
  localparam int OFF_CTRL  = 'h30;
  localparam int OFF_STAT  = 'h34;

  // config bit positions
  localparam int CFG_VS_LOW   = 8;
  localparam int CFG_DE_LOW   = 9;
  localparam int CFG_PCLK_NEG = 10;
  localparam int CFG_HS_LOW   = 11;

  // control bit positions
  localparam int CTL_EN     = 3;
  localparam int CTL_DIS    = 4;
  localparam int CTL_SOF_EN = 12;
  localparam int CTL_EOF_EN = 13;

  // strobes from control to datapath
  typedef struct packed {
    logic run;   // generator is stepping
    logic load;  // restart: clear counters, copy timing
  } lcdt_cmd_t;

endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              frameEnd,
  output lcdt_cmd_t         cmd,
  output logic              stopped,
  output logic [CNT_W-1:0]  hSyncW,
  output logic [CNT_W-1:0]  vSyncW,
  output logic [CNT_W-1:0]  hTot,
  output logic [CNT_W-1:0]  vTot,
  output logic [CNT_W-1:0]  hStart,
  output logic [CNT_W-1:0]  hEnd,
  output logic [CNT_W-1:0]  vStart,
  output logic [CNT_W-1:0]  vEnd,
  output logic              polHs,
  output logic              polVs,
  output logic              polDe,
  output logic              pclkFall,
  output logic              sofEn,
  output logic              eofEn
);

  localparam int HI = 16;

  logic enBit, disBit, running, runReq;
  logic unusedBits;

  assign runReq     = enBit & ~disBit;
  assign unusedBits = ^wrData;

  // register bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hSyncW <= '0; vSyncW <= '0; hTot <= '0; vTot <= '0;
      hStart <= '0; hEnd <= '0; vStart <= '0; vEnd <= '0;
      polHs <= 1'b0; polVs <= 1'b0; polDe <= 1'b0; pclkFall <= 1'b0;
      enBit <= 1'b0; disBit <= 1'b0; sofEn <= 1'b0; eofEn <= 1'b0;
    end else if (wrEn) begin
      case (addr)
        ADDR_W'(OFF_CFG): begin
          polHs    <= wrData[CFG_HS_LOW];
          polVs    <= wrData[CFG_VS_LOW];
          polDe    <= wrData[CFG_DE_LOW];
          pclkFall <= wrData[CFG_PCLK_NEG];
        end
        ADDR_W'(OFF_VSW): vSyncW <= wrData[CNT_W-1:0];
        ADDR_W'(OFF_HSW): hSyncW <= wrData[CNT_W-1:0];
        ADDR_W'(OFF_TOT): begin
          hTot <= wrData[HI +: CNT_W];
          vTot <= wrData[CNT_W-1:0];
        end
        ADDR_W'(OFF_HWIN): begin
          hStart <= wrData[HI +: CNT_W];
          hEnd   <= wrData[CNT_W-1:0];
        end
        ADDR_W'(OFF_VWIN): begin
          vStart <= wrData[HI +: CNT_W];
          vEnd   <= wrData[CNT_W-1:0];
        end
        ADDR_W'(OFF_CTRL): begin
          enBit  <= wrData[CTL_EN];
          disBit <= wrData[CTL_DIS];
          sofEn  <= wrData[CTL_SOF_EN];
          eofEn  <= wrData[CTL_EOF_EN];
        end
        default: ;
      endcase
    end
  end

  // run / stop sequencing: stops only on a frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      stopped <= 1'b0;
    end else if (!running && runReq) begin
      running <= 1'b1;
      stopped <= 1'b0;
    end else if (running && frameEnd && !runReq) begin
      running <= 1'b0;
      stopped <= 1'b1;
    end
  end

  assign cmd.run  = running;
  assign cmd.load = !running && runReq;

  // read mux
  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(OFF_CFG): begin
        rdData[CFG_HS_LOW]   = polHs;
        rdData[CFG_VS_LOW]   = polVs;
        rdData[CFG_DE_LOW]   = polDe;
        rdData[CFG_PCLK_NEG] = pclkFall;
      end
      ADDR_W'(OFF_VSW):  rdData = 32'(vSyncW);
      ADDR_W'(OFF_HSW):  rdData = 32'(hSyncW);
      ADDR_W'(OFF_TOT):  rdData = (32'(hTot) << HI) | 32'(vTot);
      ADDR_W'(OFF_HWIN): rdData = (32'(hStart) << HI) | 32'(hEnd);
      ADDR_W'(OFF_VWIN): rdData = (32'(vStart) << HI) | 32'(vEnd);
      ADDR_W'(OFF_CTRL): begin
        rdData[CTL_EN]     = enBit;
        rdData[CTL_DIS]    = disBit;
        rdData[CTL_SOF_EN] = sofEn;
        rdData[CTL_EOF_EN] = eofEn;
      end
      ADDR_W'(OFF_STAT): rdData[0] = stopped;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/lcdt_dpath.sv
module lcdt_dpath
  import lcdt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixEn,
  input  lcdt_cmd_t        cmd,
  input  logic [CNT_W-1:0] hSyncW,
  input  logic [CNT_W-1:0] vSyncW,
  input  logic [CNT_W-1:0] hTot,
  input  logic [CNT_W-1:0] vTot,
  input  logic [CNT_W-1:0] hStart,
  input  logic [CNT_W-1:0] hEnd,
  input  logic [CNT_W-1:0] vStart,
  input  logic [CNT_W-1:0] vEnd,
  input  logic             polHs,
  input  logic             polVs,
  input  logic             polDe,
  input  logic             pclkFall,
  input  logic             sofEn,
  input  logic             eofEn,
  output logic             frameEnd,
  output logic             hsyncPin,
  output logic             vsyncPin,
  output logic             dePin,
  output logic             pclkPin,
  output logic             pixReq,
  output logic [CNT_W-1:0] xPos,
  output logic [CNT_W-1:0] yPos,
  output logic             sofIrq,
  output logic             eofIrq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] hCnt, vCnt;
  logic [CNT_W-1:0] shHsw, shVsw, shHTot, shVTot, shHS, shHE, shVS, shVE;
  logic hsAct, vsAct, deAct, pclkR;
  logic lineEnd, lastPix, inWin, origin;

  assign lineEnd  = (hCnt == shHTot - ONE);
  assign lastPix  = lineEnd && (vCnt == shVTot - ONE);
  assign origin   = (hCnt == '0) && (vCnt == '0);
  assign inWin    = (hCnt >= shHS) && (hCnt < shHE) &&
                    (vCnt >= shVS) && (vCnt < shVE);
  assign frameEnd = cmd.run && pixEn && lastPix;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0; vCnt <= '0;
      shHsw <= '0; shVsw <= '0; shHTot <= '0; shVTot <= '0;
      shHS <= '0; shHE <= '0; shVS <= '0; shVE <= '0;
      hsAct <= 1'b0; vsAct <= 1'b0; deAct <= 1'b0; pixReq <= 1'b0;
      xPos <= '0; yPos <= '0; sofIrq <= 1'b0; eofIrq <= 1'b0;
      pclkR <= 1'b0;
    end else begin
      pclkR <= pixEn;
      if (cmd.load || !cmd.run) begin
        hsAct <= 1'b0; vsAct <= 1'b0; deAct <= 1'b0; pixReq <= 1'b0;
        xPos <= '0; yPos <= '0; sofIrq <= 1'b0; eofIrq <= 1'b0;
        if (cmd.load) begin
          hCnt <= '0; vCnt <= '0;
          shHsw <= hSyncW; shVsw <= vSyncW; shHTot <= hTot; shVTot <= vTot;
          shHS <= hStart; shHE <= hEnd; shVS <= vStart; shVE <= vEnd;
        end
      end else if (pixEn) begin
        hsAct  <= hCnt < shHsw;
        vsAct  <= vCnt < shVsw;
        deAct  <= inWin;
        pixReq <= inWin;
        xPos   <= hCnt;
        yPos   <= vCnt;
        sofIrq <= sofEn && origin;
        eofIrq <= eofEn && lastPix;
        hCnt   <= lineEnd ? '0 : hCnt + ONE;
        if (lineEnd) vCnt <= lastPix ? '0 : vCnt + ONE;
        if (lastPix) begin
          shHsw <= hSyncW; shVsw <= vSyncW; shHTot <= hTot; shVTot <= vTot;
          shHS <= hStart; shHE <= hEnd; shVS <= vStart; shVE <= vEnd;
        end
      end else begin
        pixReq <= 1'b0;
        sofIrq <= 1'b0;
        eofIrq <= 1'b0;
      end
    end
  end

  assign hsyncPin = hsAct ^ polHs;
  assign vsyncPin = vsAct ^ polVs;
  assign dePin    = deAct ^ polDe;
  assign pclkPin  = pclkR ^ pclkFall;

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              hsyncPin,
  output logic              vsyncPin,
  output logic              dePin,
  output logic              pclkPin,
  output logic              pixReq,
  output logic [CNT_W-1:0]  xPos,
  output logic [CNT_W-1:0]  yPos,
  output logic              sofIrq,
  output logic              eofIrq
);

  lcdt_cmd_t cmd;
  logic frameEnd, stopped;
  logic [CNT_W-1:0] hSyncW, vSyncW, hTot, vTot, hStart, hEnd, vStart, vEnd;
  logic polHs, polVs, polDe, pclkFall, sofEn, eofEn;

  lcdt_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .frameEnd(frameEnd), .cmd(cmd), .stopped(stopped),
    .hSyncW(hSyncW), .vSyncW(vSyncW), .hTot(hTot), .vTot(vTot),
    .hStart(hStart), .hEnd(hEnd), .vStart(vStart), .vEnd(vEnd),
    .polHs(polHs), .polVs(polVs), .polDe(polDe), .pclkFall(pclkFall),
    .sofEn(sofEn), .eofEn(eofEn)
  );

  lcdt_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .cmd(cmd),
    .hSyncW(hSyncW), .vSyncW(vSyncW), .hTot(hTot), .vTot(vTot),
    .hStart(hStart), .hEnd(hEnd), .vStart(vStart), .vEnd(vEnd),
    .polHs(polHs), .polVs(polVs), .polDe(polDe), .pclkFall(pclkFall),
    .sofEn(sofEn), .eofEn(eofEn), .frameEnd(frameEnd),
    .hsyncPin(hsyncPin), .vsyncPin(vsyncPin), .dePin(dePin),
    .pclkPin(pclkPin), .pixReq(pixReq), .xPos(xPos), .yPos(yPos),
    .sofIrq(sofIrq), .eofIrq(eofIrq)
  );

endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             pixEn,
  input logic             dePin,
  input logic             pclkPin,
  input logic             pixReq,
  input logic [CNT_W-1:0] xPos,
  input logic [CNT_W-1:0] yPos,
  input logic             sofIrq,
  input logic             eofIrq,
  input logic             polDe,
  input logic             pclkFall,
  input logic             run,
  input logic             stopped
);

  // start-of-frame pulse only at the origin
  p_sof_origin_r9: assert property (@(posedge clk) disable iff (!rstN)
    sofIrq |-> (xPos == '0) && (yPos == '0));

  // a pixel request always coincides with DE at its active level
  p_req_de_r4: assert property (@(posedge clk) disable iff (!rstN)
    pixReq |-> (dePin != polDe));

  // pixel clock pin tracks the enable one clock later
  p_pclk_delay_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((pclkPin ^ pclkFall) == $past(pixEn)));

  // once stopped, nothing moves
  p_quiet_stopped_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stopped && $past(stopped)) |->
      (!pixReq && !sofIrq && !eofIrq && xPos == '0 && yPos == '0));

  // position holds across cycles without a pixel step
  p_hold_nopix_r2: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && !$past(pixEn)) |-> ($stable(xPos) && $stable(yPos)));

endmodule

bind lcd_timing_gen lcdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .pixEn(pixEn), .dePin(dePin), .pclkPin(pclkPin),
  .pixReq(pixReq), .xPos(xPos), .yPos(yPos), .sofIrq(sofIrq),
  .eofIrq(eofIrq), .polDe(polDe), .pclkFall(pclkFall), .run(cmd.run),
  .stopped(stopped)
);

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;

  localparam int CNT_W  = 10;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixEn = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic hsyncPin, vsyncPin, dePin, pclkPin, pixReq, sofIrq, eofIrq;
  logic [CNT_W-1:0] xPos, yPos;

  lcd_timing_gen #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .hsyncPin(hsyncPin),
    .vsyncPin(vsyncPin), .dePin(dePin), .pclkPin(pclkPin), .pixReq(pixReq),
    .xPos(xPos), .yPos(yPos), .sofIrq(sofIrq), .eofIrq(eofIrq)
  );

  always #2 clk = ~clk;  // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct {
    int   due;
    logic hs, vs, de, pr, sof, eof, pc;
    int   x, y;
  } item_t;
  item_t q[$];

  // reference state: live registers, working copies, position
  int lHsw, lVsw, lHT, lVT, lHS, lHE, lVS, lVE;
  int sHsw, sVsw, sHT, sVT, sHS, sHE, sVS, sVE;
  int mH, mV;
  bit mRun, runReq, sofE, eofE, pHs, pVs, pDe, pFall;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare each expected item in the cycle it is due
  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      chk("R3/R5 hsync", hsyncPin, it.hs);
      chk("R3/R5 vsync", vsyncPin, it.vs);
      chk("R4/R5 de", dePin, it.de);
      chk("R4 pixReq", pixReq, it.pr);
      chk("R2 xPos", xPos, it.x);
      chk("R2 yPos", yPos, it.y);
      chk("R9 sofIrq", sofIrq, it.sof);
      chk("R9 eofIrq", eofIrq, it.eof);
      chk("R6 pclk", pclkPin, it.pc);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic loadShadow();
    sHsw = lHsw; sVsw = lVsw; sHT = lHT; sVT = lVT;
    sHS = lHS; sHE = lHE; sVS = lVS; sVE = lVE;
  endtask

  task automatic regWrite(input int a, input logic [31:0] d);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input string tag, input int a, input logic [31:0] exp);
    addr = ADDR_W'(a);
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic wrTiming(input int a, input logic [31:0] d);
    regWrite(a, d);
    case (a)
      'h04: lVsw = int'(d[9:0]);
      'h08: lHsw = int'(d[9:0]);
      'h0C: begin lHT = int'(d[25:16]); lVT = int'(d[9:0]); end
      'h10: begin lHS = int'(d[25:16]); lHE = int'(d[9:0]); end
      'h14: begin lVS = int'(d[25:16]); lVE = int'(d[9:0]); end
      default: ;
    endcase
  endtask

  task automatic wrCfg(input logic [31:0] d);
    regWrite('h00, d);
    pVs = d[8]; pDe = d[9]; pFall = d[10]; pHs = d[11];
  endtask

  task automatic wrCtrl(input logic [31:0] d);
    regWrite('h30, d);
    runReq = d[3] && !d[4];
    sofE = d[12]; eofE = d[13];
    if (!mRun && runReq) begin
      mRun = 1'b1; mH = 0; mV = 0; loadShadow();
    end
    idle(1);  // restart strobe lands on the next edge
  endtask

  // one pixel-enable cycle, expected result pushed for the monitor
  task automatic step();
    item_t it;
    bit last;
    it.due = cyc + 1;
    it.pc = 1'b1 ^ pFall;
    if (mRun) begin
      last   = (mH == sHT - 1) && (mV == sVT - 1);
      it.hs  = (mH < sHsw) ^ pHs;
      it.vs  = (mV < sVsw) ^ pVs;
      it.pr  = (mH >= sHS) && (mH < sHE) && (mV >= sVS) && (mV < sVE);
      it.de  = it.pr ^ pDe;
      it.x   = mH; it.y = mV;
      it.sof = sofE && mH == 0 && mV == 0;
      it.eof = eofE && last;
      if (mH == sHT - 1) begin
        mH = 0;
        mV = last ? 0 : mV + 1;
      end else mH = mH + 1;
      if (last) begin
        loadShadow();
        if (!runReq) mRun = 1'b0;
      end
    end else begin
      it.hs = pHs; it.vs = pVs; it.de = pDe; it.pr = 1'b0;
      it.x = 0; it.y = 0; it.sof = 1'b0; it.eof = 1'b0;
    end
    q.push_back(it);
    pixEn = 1'b1;
    @(negedge clk);
    pixEn = 1'b0;
  endtask

  task automatic steps(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step();
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    lHsw = 0; lVsw = 0; lHT = 0; lVT = 0; lHS = 0; lHE = 0; lVS = 0; lVE = 0;
    loadShadow();
    mH = 0; mV = 0; mRun = 1'b0; runReq = 1'b0; sofE = 1'b0; eofE = 1'b0;
    pHs = 1'b0; pVs = 1'b0; pDe = 1'b0; pFall = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R11: reset state
    chk("R11 hsync", hsyncPin, 1'b0);
    chk("R11 vsync", vsyncPin, 1'b0);
    chk("R11 de", dePin, 1'b0);
    chk("R11 pixReq", pixReq, 1'b0);
    chk("R11 irqs", {sofIrq, eofIrq}, 2'b00);
    regRead("R11 status", 'h34, 32'h0);

    // R1: program a small panel and read the packing back
    wrTiming('h08, 32'd2);
    wrTiming('h04, 32'd1);
    wrTiming('h0C, (32'd14 << 16) | 32'd6);
    wrTiming('h10, (32'd4 << 16) | 32'd12);
    wrTiming('h14, (32'd2 << 16) | 32'd5);
    regRead("R1 totals", 'h0C, 32'h000E_0006);
    regRead("R1 hwin", 'h10, 32'h0004_000C);
    regRead("R1 vwin", 'h14, 32'h0002_0005);
    regRead("R1 hsw", 'h08, 32'h2);

    // R7/R9: start with both interrupts, back-to-back pixels then gaps
    wrCtrl(32'h0000_3008);
    regRead("R7 status cleared", 'h34, 32'h0);
    steps(84, 0);
    steps(84, 1);

    // R10: rewrite window and sync mid-frame
    steps(20, 0);
    wrTiming('h10, (32'd3 << 16) | 32'd10);
    wrTiming('h04, 32'd2);
    steps(40, 0);
    wrTiming('h14, (32'd1 << 16) | 32'd4);
    steps(120, 2);

    // R5/R6: invert all pins and the pixel clock
    wrCfg(32'h0000_0F00);
    regRead("R5 cfg readback", 'h00, 32'h0000_0F00);
    steps(90, 0);

    // R8: stop request partway through a frame
    wrCtrl(32'h0000_3018);
    regRead("R8 status before frame end", 'h34, 32'h0);
    steps(100, 0);
    regRead("R8 status stopped", 'h34, 32'h1);
    chk("R8 idle hsync level", hsyncPin, 1'b1);
    chk("R8 idle de level", dePin, 1'b1);
    steps(5, 1);

    // R7/R9: restart with interrupts masked, polarities back to high
    wrCfg(32'h0);
    wrCtrl(32'h0000_0008);
    regRead("R7 status cleared again", 'h34, 32'h0);
    steps(170, 0);

    // R8: stop by clearing enable
    wrCtrl(32'h0);
    steps(100, 0);
    regRead("R8 status after enable clear", 'h34, 32'h1);

    idle(3);
    chk("R2 all items compared", q.size(), 0);
    finishRun();
  end

endmodule